// File: doc/BRIEF.md
# Two-Step Frequency/Voltage Change Orderer

This block takes a request to move a core to a new operating point. The request gives a target frequency code and a target voltage code. The block compares the request with the current codes reported by the status register. It then emits one or two writes to the frequency/voltage control register, and each write changes exactly one of the two quantities.

Safety depends on the order of the writes. When the operating multiplier falls, the frequency moves first. In every other case the voltage moves first. The multiplier for each code comes from a 32-entry table that is not monotonic, so the direction of a change is judged on the table values and never on the raw codes.

Each command word carries both target codes, one change strobe, a settling count, and the ratio-select bit carried over from the control register. When the errata input is set, an interrupt-mask output stays high for the whole write sequence.

Top module: `fv_step_orderer`

## Requirements
- R1: When the requested frequency and voltage codes both equal the current codes, no write is issued and `done_o` pulses in the cycle after the request is accepted.
- R2: When the table multiplier of the target frequency code is lower than that of the current code, the first write carries the frequency strobe (bit 16). A second write with the voltage strobe (bit 17) follows only if the voltage codes differ.
- R3: In all other cases, including equal multipliers, the first write carries the voltage strobe (bit 17). A second write with the frequency strobe (bit 16) follows only if the frequency codes differ.
- R4: Every command word holds the target frequency code in bits 4:0, the target voltage code in bits 12:8, and exactly one of the two strobes in bits 16 and 17. The 20-bit settling count sits in bits 51:32.
- R5: Bit 20 of every command word equals `ratio_sel_i` as sampled when the request was accepted. Every bit not named in R4 or R5 is zero.
- R6: The multiplier table holds ten times the multiplier:
  - codes 0 to 3 give 110 to 125 in steps of 5;
  - codes 4 to 15 give 50 to 105 in steps of 5;
  - codes 16 to 29 give 30, 190, 40, 200, 130, 135, 140, 210, 150, 225, 160, 165, 170 and 180;
  - codes 30 and 31 give 0.
- R7: With `errata_i` high at acceptance, `irq_mask_o` is high from the cycle after acceptance until the last write is accepted. With `errata_i` low it stays low.
- R8: A write holds `wr_valid_o` and `wr_data_o` steady until `wr_ready_i` accepts it. The second write is presented only after the first has been accepted.
- R9: `req_ready_o` is low while a sequence is in progress. `done_o` pulses for one cycle after the last write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, will accept a request |
| req_fid_i | input | FID_W | Target frequency code |
| req_vid_i | input | VID_W | Target voltage code |
| cur_fid_i | input | FID_W | Current frequency code from status register |
| cur_vid_i | input | VID_W | Current voltage code from status register |
| settle_i | input | SETTLE_W | Settling count placed in command words |
| ratio_sel_i | input | 1 | Ratio-select bit of last control value |
| errata_i | input | 1 | Mask interrupts during the sequence |
| wr_valid_o | output | 1 | Control write valid |
| wr_ready_i | input | 1 | Control write accepted |
| wr_data_o | output | CTL_W | Control command word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| irq_mask_o | output | 1 | Interrupt mask request |

## Verification
The bench builds the block with its default widths: 5-bit codes, a 20-bit settling count and a 64-bit word. At these widths every table code is reachable, including the two zero entries. The settling field can be driven to all ones, which shows that it neither spills into neighbouring bits nor gets truncated.

A pseudo-random `wr_ready_i` pattern makes each write stall for a varying number of cycles. Requests are also queued back to back, which exercises the hold-off and the stable-data rule.

// File: rtl/fvo_pkg.sv
package fvo_pkg;
  localparam int FID_LSB    = 0;
  localparam int VID_LSB    = 8;
  localparam int FSTB_BIT   = 16;
  localparam int VSTB_BIT   = 17;
  localparam int RATIO_BIT  = 20;
  localparam int SETTLE_LSB = 32;
  localparam int MULT_W     = 8;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } fvo_state_e;
endpackage

// File: rtl/fvo_mult_lut.sv
module fvo_mult_lut
  import fvo_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [MULT_W-1:0] mult_o
);
  localparam int NUM_CODES = 1 << CODE_W;

  // ten times the multiplier; 0 marks an unusable code
  always_comb begin
    int c;
    c = int'(code_i);
    if (c < 4)              mult_o = MULT_W'(110 + 5 * c);
    else if (c < 16)        mult_o = MULT_W'(50 + 5 * (c - 4));
    else if (c >= NUM_CODES) mult_o = '0;
    else begin
      case (c)
        16: mult_o = MULT_W'(30);
        17: mult_o = MULT_W'(190);
        18: mult_o = MULT_W'(40);
        19: mult_o = MULT_W'(200);
        20: mult_o = MULT_W'(130);
        21: mult_o = MULT_W'(135);
        22: mult_o = MULT_W'(140);
        23: mult_o = MULT_W'(210);
        24: mult_o = MULT_W'(150);
        25: mult_o = MULT_W'(225);
        26: mult_o = MULT_W'(160);
        27: mult_o = MULT_W'(165);
        28: mult_o = MULT_W'(170);
        29: mult_o = MULT_W'(180);
        default: mult_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/fvo_cmd_build.sv
module fvo_cmd_build
  import fvo_pkg::*;
#(
  parameter int FID_W    = 5,
  parameter int VID_W    = 5,
  parameter int SETTLE_W = 20,
  parameter int CTL_W    = 64
) (
  input  logic [FID_W-1:0]    fid_i,
  input  logic [VID_W-1:0]    vid_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic                ratio_i,
  input  logic                fstb_i,
  input  logic                vstb_i,
  output logic [CTL_W-1:0]    word_o
);
  always_comb begin
    word_o = '0;
    word_o[FID_LSB +: FID_W]       = fid_i;
    word_o[VID_LSB +: VID_W]       = vid_i;
    word_o[FSTB_BIT]               = fstb_i;
    word_o[VSTB_BIT]               = vstb_i;
    word_o[RATIO_BIT]              = ratio_i;
    word_o[SETTLE_LSB +: SETTLE_W] = settle_i;
  end
endmodule

// File: rtl/fvo_seq.sv
module fvo_seq
  import fvo_pkg::*;
#(
  parameter int FID_W    = 5,
  parameter int VID_W    = 5,
  parameter int SETTLE_W = 20
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [FID_W-1:0]    req_fid_i,
  input  logic [VID_W-1:0]    req_vid_i,
  input  logic [FID_W-1:0]    cur_fid_i,
  input  logic [VID_W-1:0]    cur_vid_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic                ratio_i,
  input  logic                errata_i,
  input  logic [MULT_W-1:0]   tgt_mult_i,
  input  logic [MULT_W-1:0]   cur_mult_i,
  output logic                wr_valid_o,
  input  logic                wr_ready_i,
  output logic [FID_W-1:0]    fid_o,
  output logic [VID_W-1:0]    vid_o,
  output logic [SETTLE_W-1:0] settle_o,
  output logic                ratio_o,
  output logic                fstb_o,
  output logic                vstb_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                irq_mask_o
);
  fvo_state_e state_q;
  logic freq_first_q, need2_q, done_q, irq_q;

  logic accept, fid_same, vid_same, noop, going_down, need2, wr_fire;

  assign accept     = req_valid_i && (state_q == ST_IDLE);
  assign fid_same   = (req_fid_i == cur_fid_i);
  assign vid_same   = (req_vid_i == cur_vid_i);
  assign noop       = fid_same && vid_same;
  assign going_down = (tgt_mult_i < cur_mult_i);
  assign need2      = going_down ? !vid_same : !fid_same;
  assign wr_fire    = wr_valid_o && wr_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      freq_first_q <= 1'b0;
      need2_q      <= 1'b0;
      done_q       <= 1'b0;
      irq_q        <= 1'b0;
      fid_o        <= '0;
      vid_o        <= '0;
      settle_o     <= '0;
      ratio_o      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (noop) begin
              done_q <= 1'b1;
            end else begin
              state_q      <= ST_FIRST;
              freq_first_q <= going_down;
              need2_q      <= need2;
              irq_q        <= errata_i;
              fid_o        <= req_fid_i;
              vid_o        <= req_vid_i;
              settle_o     <= settle_i;
              ratio_o      <= ratio_i;
            end
          end
        end
        ST_FIRST: begin
          if (wr_fire) begin
            if (need2_q) begin
              state_q <= ST_SECOND;
            end else begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              irq_q   <= 1'b0;
            end
          end
        end
        ST_SECOND: begin
          if (wr_fire) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            irq_q   <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign busy_o      = (state_q != ST_IDLE);
  assign wr_valid_o  = (state_q == ST_FIRST) || (state_q == ST_SECOND);
  assign fstb_o      = ((state_q == ST_FIRST) && freq_first_q) ||
                       ((state_q == ST_SECOND) && !freq_first_q);
  assign vstb_o      = ((state_q == ST_FIRST) && !freq_first_q) ||
                       ((state_q == ST_SECOND) && freq_first_q);
  assign done_o      = done_q;
  assign irq_mask_o  = irq_q;

  p_noop_done_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && noop) |=> (done_o && !wr_valid_o));

  p_freq_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !noop && going_down) |=> (fstb_o && !vstb_o));

  p_volt_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !noop && !going_down) |=> (vstb_o && !fstb_o));

  p_one_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> ($countones({fstb_o, vstb_o}) == 1));

  p_irq_on_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !noop && errata_i) |=> irq_mask_o);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=>
      (wr_valid_o && $stable({fstb_o, vstb_o, fid_o, vid_o, settle_o, ratio_o})));

  p_second_swaps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_FIRST) && wr_fire && need2_q) |=>
      (wr_valid_o && (fstb_o != $past(fstb_o))));

  p_holdoff_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> !req_ready_o);
endmodule

// File: rtl/fv_step_orderer.sv
module fv_step_orderer
  import fvo_pkg::*;
#(
  parameter int FID_W    = 5,
  parameter int VID_W    = 5,
  parameter int SETTLE_W = 20,
  parameter int CTL_W    = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [FID_W-1:0]    req_fid_i,
  input  logic [VID_W-1:0]    req_vid_i,
  input  logic [FID_W-1:0]    cur_fid_i,
  input  logic [VID_W-1:0]    cur_vid_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic                ratio_sel_i,
  input  logic                errata_i,
  output logic                wr_valid_o,
  input  logic                wr_ready_i,
  output logic [CTL_W-1:0]    wr_data_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                irq_mask_o
);
  localparam int NUM_LUT = 2;

  logic [FID_W-1:0]  lut_code [NUM_LUT];
  logic [MULT_W-1:0] lut_mult [NUM_LUT];

  assign lut_code[0] = req_fid_i;
  assign lut_code[1] = cur_fid_i;

  for (genvar gi = 0; gi < NUM_LUT; gi++) begin : g_lut
    fvo_mult_lut #(.CODE_W(FID_W)) u_lut (
      .code_i (lut_code[gi]),
      .mult_o (lut_mult[gi])
    );
  end

  logic [FID_W-1:0]    fid_q;
  logic [VID_W-1:0]    vid_q;
  logic [SETTLE_W-1:0] settle_q;
  logic                ratio_q, fstb, vstb;

  fvo_seq #(.FID_W(FID_W), .VID_W(VID_W), .SETTLE_W(SETTLE_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_fid_i   (req_fid_i),
    .req_vid_i   (req_vid_i),
    .cur_fid_i   (cur_fid_i),
    .cur_vid_i   (cur_vid_i),
    .settle_i    (settle_i),
    .ratio_i     (ratio_sel_i),
    .errata_i    (errata_i),
    .tgt_mult_i  (lut_mult[0]),
    .cur_mult_i  (lut_mult[1]),
    .wr_valid_o  (wr_valid_o),
    .wr_ready_i  (wr_ready_i),
    .fid_o       (fid_q),
    .vid_o       (vid_q),
    .settle_o    (settle_q),
    .ratio_o     (ratio_q),
    .fstb_o      (fstb),
    .vstb_o      (vstb),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .irq_mask_o  (irq_mask_o)
  );

  fvo_cmd_build #(.FID_W(FID_W), .VID_W(VID_W), .SETTLE_W(SETTLE_W), .CTL_W(CTL_W)) u_cmd (
    .fid_i    (fid_q),
    .vid_i    (vid_q),
    .settle_i (settle_q),
    .ratio_i  (ratio_q),
    .fstb_i   (fstb),
    .vstb_i   (vstb),
    .word_o   (wr_data_o)
  );

  p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !irq_mask_o);
endmodule

// File: tb/test_fv_step_orderer.sv
module test_fv_step_orderer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [4:0]  req_fid = '0, cur_fid = '0;
  logic [4:0]  req_vid = '0, cur_vid = '0;
  logic [19:0] settle = '0;
  logic        ratio = 1'b0, errata = 1'b0, wr_ready = 1'b0;
  logic        req_ready, wr_valid, busy, done, irq_mask;
  logic [63:0] wr_data;

  int n_vec = 0, n_bad = 0;
  string cur_tag = "R9";
  bit finished = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit stall_on = 1'b1;

  always #4 clk = ~clk;

  fv_step_orderer i_fv_step_orderer (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_fid_i(req_fid), .req_vid_i(req_vid),
    .cur_fid_i(cur_fid), .cur_vid_i(cur_vid),
    .settle_i(settle), .ratio_sel_i(ratio), .errata_i(errata),
    .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_data_o(wr_data),
    .busy_o(busy), .done_o(done), .irq_mask_o(irq_mask)
  );

  function automatic int mult10(int c);
    int hi [14] = '{30, 190, 40, 200, 130, 135, 140, 210, 150, 225, 160, 165, 170, 180};
    if (c <= 3) return 110 + 5 * c;
    if (c <= 15) return 50 + 5 * (c - 4);
    if (c <= 29) return hi[c - 16];
    return 0;
  endfunction

  // behavioural reference
  logic [63:0] q[$];
  bit m_idle = 1, m_done = 0, m_irq = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_idle = 1; m_done = 0; m_irq = 0;
    end else begin
      m_done = 0;
      if (m_idle) begin
        if (req_valid) begin
          logic [63:0] base;
          base = 64'(req_fid) | (64'(req_vid) << 8) | (64'(ratio) << 20) | (64'(settle) << 32);
          if (req_fid == cur_fid && req_vid == cur_vid) m_done = 1;
          else begin
            if (mult10(int'(req_fid)) < mult10(int'(cur_fid))) begin
              q.push_back(base | (64'd1 << 16));
              if (req_vid != cur_vid) q.push_back(base | (64'd1 << 17));
            end else begin
              q.push_back(base | (64'd1 << 17));
              if (req_fid != cur_fid) q.push_back(base | (64'd1 << 16));
            end
            m_idle = 0; m_irq = errata;
          end
        end
      end else if (wr_ready) begin
        void'(q.pop_front());
        if (q.size() == 0) begin m_idle = 1; m_done = 1; m_irq = 0; end
      end
    end
  end

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!finished) begin
    chk("R9", "req_ready", 64'(req_ready), 64'(m_idle));
    chk("R9", "busy", 64'(busy), 64'(!m_idle));
    chk("R8", "wr_valid", 64'(wr_valid), 64'(!m_idle));
    if (!m_idle && wr_valid) chk(cur_tag, "wr_data", wr_data, q[0]);
    chk("R7", "irq_mask", 64'(irq_mask), 64'(m_irq && !m_idle));
    chk("R1", "done", 64'(done), 64'(m_done));
  end

  initial forever begin
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    wr_ready = stall_on ? lfsr[0] & lfsr[3] : 1'b1;
  end

  task automatic send(input string tag, input int f, input int v, input int cf, input int cv,
                      input bit er, input bit ra, input int st);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_tag = tag;
    req_fid = 5'(f); req_vid = 5'(v); cur_fid = 5'(cf); cur_vid = 5'(cv);
    errata = er; ratio = ra; settle = 20'(st); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    send("R1", 3, 7, 3, 7, 1, 0, 100);        drain();
    send("R2", 4, 10, 0, 6, 0, 0, 5);          drain();  // 11.0 -> 5.0
    send("R2", 4, 6, 0, 6, 0, 0, 5);           drain();
    send("R3", 0, 10, 4, 6, 0, 0, 9);          drain();  // 5.0 -> 11.0, raw code lower
    send("R3", 4, 3, 4, 6, 0, 0, 9);           drain();
    send("R6", 31, 3, 30, 6, 0, 0, 1);         drain();  // equal zero entries
    send("R6", 16, 2, 0, 9, 0, 0, 1);          drain();  // raw code up, multiplier down
    send("R6", 30, 2, 4, 2, 0, 0, 1);          drain();
    send("R6", 17, 1, 25, 4, 0, 0, 1);         drain();  // 19.0 < 22.5
    send("R5", 12, 21, 7, 9, 1, 1, 20'hFFFFF); drain();
    send("R4", 29, 31, 0, 0, 1, 0, 20'h5A5A5); drain();
    // back-to-back requests, held off while busy
    for (int i = 0; i < 40; i++) begin
      send("R8", (i * 7) % 32, (i * 5) % 32, (i * 11) % 32, (i * 3) % 32, i[0], i[1], i * 977);
    end
    drain();
    stall_on = 1'b0;
    for (int i = 0; i < 32; i++) begin
      send("R6", i, 4, (i + 9) % 32, 4, 0, 0, i);
    end
    drain();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule